// File: doc/BRIEF.md
# Frame-Paced Bouncing Sprite Renderer

This block paints one solid red square on a 640x480 raster and moves it across the screen at a speed a viewer can follow. An existing timing generator supplies the pixel coordinates, and the block returns an 8-bit colour in 3-3-2 form (three red bits, three green bits, two blue bits), one clock after each coordinate. At 60 frames per second the image would move far too fast if the square advanced every frame. The block therefore counts frame ends and advances the square only once every N frames, where N comes from an input.

Each axis of motion is a two-state machine. In the states `MOVE_FWD` and `MOVE_REV` the square moves toward larger or smaller coordinates. On every move step the machine takes one of four named transitions:

- `advance`: FWD stays FWD and adds 2.
- `bounce_far`: FWD goes to REV, and the position is clamped to the far limit.
- `retreat`: REV stays REV and subtracts 2.
- `bounce_near`: REV goes to FWD, and the position is clamped to 0.

The square always stays fully visible, and the position never changes in the middle of a frame.

Top module: `bounce_sprite`

## Requirements
- R1: While `rst` is high on a clock edge, the colour outputs become 0, the square returns to its home corner (100,100), and both axes head toward larger coordinates.
- R2: The colour outputs are registered. They show the result for the coordinate presented on the previous clock edge.
- R3: The square is 16x16 pixels with top-left corner (bx,by). A pixel with bx <= x <= bx+15 and by <= y <= by+15 is pure red: red=3'b111, green=3'b000, blue=2'b00, which is 8'hE0 as {red,grn,blu}.
- R4: A pixel with x >= 640 or y >= 480 gives all-zero colour. Every visible pixel outside the square is black (all zero).
- R5: A frame end is the single cycle with coordinate (799,524). No other coordinate advances the frame count, including x=799 on another line and y=524 in another column.
- R6: The square moves on exactly one frame end out of every N, where N is `frames_per_move`, and stays still at all other times. N of 0 or 1 means it moves on every frame end.
- R7: A move changes each axis by 2 pixels in that axis's current direction (transitions `advance` and `retreat`).
- R8: Moving forward, when position+2 >= 624 on x (640-16) or 464 on y (480-16), the position becomes that limit and the direction reverses (`bounce_far`).
- R9: Moving backward, when position <= 2, the position becomes 0 and the direction becomes forward (`bounce_near`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| px_x | input | 10 | Current horizontal pixel coordinate (0..799) |
| px_y | input | 10 | Current vertical line coordinate (0..524) |
| frames_per_move | input | 8 | Frame ends per move step (N) |
| red | output | 3 | Red colour component |
| grn | output | 3 | Green colour component |
| blu | output | 2 | Blue colour component |

## Verification
The assertions check the following on every cycle:

- Any lit pixel is pure red.
- Off-screen coordinates give black on the next cycle.
- A move step only happens on the (799,524) coordinate.
- The position holds still between steps and changes on every step.
- The square stays inside its limits.
- Reset returns the square to its home corner.

Only the bench scenarios can show the rest:

- The exact N-frame cadence, including N of 0.
- The 2-pixel step size.
- The clamp values at each edge.
- The one-cycle colour latency.
- The precise pixel extent of the square.

The bench shows these by comparing probed pixels against an independent position model.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

    typedef enum logic {
        MOVE_FWD = 1'b0,
        MOVE_REV = 1'b1
    } heading_t;

    typedef struct packed {
        logic [2:0] r;
        logic [2:0] g;
        logic [1:0] b;
    } rgb332_t;

    localparam rgb332_t RGB_BLACK = '{r: 3'b000, g: 3'b000, b: 2'b00};
    localparam rgb332_t RGB_BALL  = '{r: 3'b111, g: 3'b000, b: 2'b00};

endpackage

// File: rtl/frame_pacer.sv
module frame_pacer #(
    parameter int CW      = 10,
    parameter int NW      = 8,
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] px_x,
    input  logic [CW-1:0] px_y,
    input  logic [NW-1:0] period,
    output logic          step
);
    localparam logic [CW-1:0] H_END = CW'(H_TOTAL - 1);
    localparam logic [CW-1:0] V_END = CW'(V_TOTAL - 1);

    logic [NW-1:0] frame_cnt_q;
    logic [NW:0]   cnt_plus;
    logic          frame_end;
    logic          last_frame;

    // A frame closes on the final pixel of the final line only.
    assign frame_end  = (px_x == H_END) && (px_y == V_END);
    assign cnt_plus   = {1'b0, frame_cnt_q} + (NW+1)'(1);
    // N of 0 or 1 makes every frame end the last one of its group.
    assign last_frame = (cnt_plus >= {1'b0, period});
    assign step       = frame_end && last_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt_q <= '0;
        end else if (frame_end) begin
            if (last_frame) begin
                frame_cnt_q <= '0;
            end else begin
                frame_cnt_q <= cnt_plus[NW-1:0];
            end
        end
    end

endmodule

// File: rtl/axis_bounce.sv
module axis_bounce
    import sprite_pkg::*;
#(
    parameter int       CW        = 10,
    parameter int       EXTENT    = 640,
    parameter int       SIZE      = 16,
    parameter int       STEP      = 2,
    parameter int       START     = 100,
    parameter heading_t START_DIR = MOVE_FWD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] pos,
    output heading_t      heading
);
    localparam logic [CW:0]   FAR_W  = (CW+1)'(EXTENT - SIZE);
    localparam logic [CW:0]   STEP_W = (CW+1)'(STEP);
    localparam logic [CW-1:0] HOME   = CW'(START);

    heading_t      state_q, state_d;
    logic [CW-1:0] pos_q, pos_d;
    logic [CW:0]   ahead;

    assign ahead = {1'b0, pos_q} + STEP_W;

    // Next state and next position.
    // Transitions: advance, bounce_far, retreat, bounce_near.
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (step) begin
            unique case (state_q)
                MOVE_FWD: begin
                    if (ahead >= FAR_W) begin
                        pos_d   = FAR_W[CW-1:0];      // bounce_far
                        state_d = MOVE_REV;
                    end else begin
                        pos_d   = ahead[CW-1:0];      // advance
                    end
                end
                MOVE_REV: begin
                    if ({1'b0, pos_q} <= STEP_W) begin
                        pos_d   = '0;                 // bounce_near
                        state_d = MOVE_FWD;
                    end else begin
                        pos_d   = pos_q - STEP_W[CW-1:0];  // retreat
                    end
                end
                default: begin
                    state_d = START_DIR;
                    pos_d   = HOME;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= START_DIR;
        end else begin
            state_q <= state_d;
        end
    end

    // Output (position) register.
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= HOME;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos     = pos_q;
    assign heading = state_q;

endmodule

// File: rtl/sprite_shader.sv
module sprite_shader
    import sprite_pkg::*;
#(
    parameter int CW    = 10,
    parameter int SIZE  = 16,
    parameter int H_VIS = 640,
    parameter int V_VIS = 480
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] px_x,
    input  logic [CW-1:0] px_y,
    input  logic [CW-1:0] ball_x,
    input  logic [CW-1:0] ball_y,
    output rgb332_t       pix
);
    localparam logic [CW-1:0] H_LIM  = CW'(H_VIS);
    localparam logic [CW-1:0] V_LIM  = CW'(V_VIS);
    localparam logic [CW:0]   SIZE_W = (CW+1)'(SIZE);

    logic [CW:0] right_edge, bottom_edge;
    logic        on_screen, in_x, in_y;
    rgb332_t     pix_d;

    assign right_edge  = {1'b0, ball_x} + SIZE_W;
    assign bottom_edge = {1'b0, ball_y} + SIZE_W;
    assign on_screen   = (px_x < H_LIM) && (px_y < V_LIM);
    assign in_x        = (px_x >= ball_x) && ({1'b0, px_x} < right_edge);
    assign in_y        = (px_y >= ball_y) && ({1'b0, px_y} < bottom_edge);

    // Every pixel gets an explicit colour; blanking wins over the ball.
    always_comb begin
        if (!on_screen) begin
            pix_d = RGB_BLACK;
        end else if (in_x && in_y) begin
            pix_d = RGB_BALL;
        end else begin
            pix_d = RGB_BLACK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= RGB_BLACK;
        end else begin
            pix <= pix_d;
        end
    end

endmodule

// File: rtl/bounce_sprite.sv
module bounce_sprite
    import sprite_pkg::*;
#(
    parameter int CW      = 10,
    parameter int NW      = 8,
    parameter int H_VIS   = 640,
    parameter int V_VIS   = 480,
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525,
    parameter int SIZE    = 16,
    parameter int STEP    = 2,
    parameter int HOME_X  = 100,
    parameter int HOME_Y  = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] px_x,
    input  logic [CW-1:0] px_y,
    input  logic [NW-1:0] frames_per_move,
    output logic [2:0]    red,
    output logic [2:0]    grn,
    output logic [1:0]    blu
);
    logic          move_step;
    logic [CW-1:0] ball_x, ball_y;
    heading_t      head_x, head_y;
    rgb332_t       pix;

    frame_pacer #(
        .CW(CW), .NW(NW), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
    ) u_pacer (
        .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y),
        .period(frames_per_move), .step(move_step)
    );

    axis_bounce #(
        .CW(CW), .EXTENT(H_VIS), .SIZE(SIZE), .STEP(STEP),
        .START(HOME_X), .START_DIR(MOVE_FWD)
    ) u_axis_x (
        .clk(clk), .rst(rst), .step(move_step), .pos(ball_x), .heading(head_x)
    );

    axis_bounce #(
        .CW(CW), .EXTENT(V_VIS), .SIZE(SIZE), .STEP(STEP),
        .START(HOME_Y), .START_DIR(MOVE_FWD)
    ) u_axis_y (
        .clk(clk), .rst(rst), .step(move_step), .pos(ball_y), .heading(head_y)
    );

    sprite_shader #(
        .CW(CW), .SIZE(SIZE), .H_VIS(H_VIS), .V_VIS(V_VIS)
    ) u_shader (
        .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y),
        .ball_x(ball_x), .ball_y(ball_y), .pix(pix)
    );

    assign red = pix.r;
    assign grn = pix.g;
    assign blu = pix.b;

endmodule

// File: rtl/bounce_sprite_props.sv
module bounce_sprite_props #(
    parameter int CW     = 10,
    parameter int H_VIS  = 640,
    parameter int V_VIS  = 480,
    parameter int SIZE   = 16,
    parameter int HOME_X = 100,
    parameter int HOME_Y = 100
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] px_x,
    input logic [CW-1:0] px_y,
    input logic [2:0]    red,
    input logic [2:0]    grn,
    input logic [1:0]    blu,
    input logic          move_step,
    input logic [CW-1:0] ball_x,
    input logic [CW-1:0] ball_y
);
    logic [7:0] colour;
    assign colour = {red, grn, blu};

    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (ball_x == CW'(HOME_X)) && (ball_y == CW'(HOME_Y)) && (colour == 8'h00));

    p_ball_red_r3: assert property (@(posedge clk) disable iff (rst)
        (colour != 8'h00) |-> (colour == 8'hE0));

    p_blank_offscreen_r4: assert property (@(posedge clk) disable iff (rst)
        ((px_x >= CW'(H_VIS)) || (px_y >= CW'(V_VIS))) |=> (colour == 8'h00));

    p_step_at_frame_end_r5: assert property (@(posedge clk) disable iff (rst)
        move_step |-> ((px_x == CW'(799)) && (px_y == CW'(524))));

    p_hold_between_steps_r6: assert property (@(posedge clk) disable iff (rst)
        !move_step |=> ($stable(ball_x) && $stable(ball_y)));

    p_moves_on_step_r7: assert property (@(posedge clk) disable iff (rst)
        move_step |=> ((ball_x != $past(ball_x)) && (ball_y != $past(ball_y))));

    p_in_bounds_r8: assert property (@(posedge clk) disable iff (rst)
        (ball_x <= CW'(H_VIS - SIZE)) && (ball_y <= CW'(V_VIS - SIZE)));

endmodule

bind bounce_sprite bounce_sprite_props #(
    .CW(CW), .H_VIS(H_VIS), .V_VIS(V_VIS), .SIZE(SIZE),
    .HOME_X(HOME_X), .HOME_Y(HOME_Y)
) u_props (
    .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y),
    .red(red), .grn(grn), .blu(blu),
    .move_step(move_step), .ball_x(ball_x), .ball_y(ball_y)
);

// File: tb/bounce_sprite_bench.sv
module bounce_sprite_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] px_x = '0;
    logic [9:0] px_y = '0;
    logic [7:0] frames_per_move = 8'd1;
    logic [2:0] red;
    logic [2:0] grn;
    logic [1:0] blu;

    always #10 clk = ~clk;

    bounce_sprite u_bounce_sprite (
        .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y),
        .frames_per_move(frames_per_move),
        .red(red), .grn(grn), .blu(blu)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
        int         x;
        int         y;
    } item_t;

    item_t q[$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Independent position model.
    int mx, my, mdx, mdy, mcnt, mn;

    function automatic logic [7:0] model_colour(int x, int y);
        if (x >= 640 || y >= 480) return 8'h00;
        if (x >= mx && x < mx + 16 && y >= my && y < my + 16) return 8'hE0;
        return 8'h00;
    endfunction

    task automatic model_home();
        mx = 100; my = 100; mdx = 1; mdy = 1; mcnt = 0;
    endtask

    task automatic model_axis(inout int p, inout int d, input int lim);
        if (d > 0) begin
            if (p + 2 >= lim) begin p = lim; d = -1; end
            else p = p + 2;
        end else begin
            if (p <= 2) begin p = 0; d = 1; end
            else p = p - 2;
        end
    endtask

    task automatic model_frame_end();
        if (mcnt + 1 >= mn) begin
            mcnt = 0;
            model_axis(mx, mdx, 624);
            model_axis(my, mdy, 464);
        end else begin
            mcnt = mcnt + 1;
        end
    endtask

    // Driver: present one coordinate and queue its expected colour.
    task automatic drive(int x, int y, string tag);
        item_t it;
        @(negedge clk);
        px_x = 10'(x);
        px_y = 10'(y);
        it.exp = rst ? 8'h00 : model_colour(x, y);
        it.tag = tag; it.x = x; it.y = y;
        q.push_back(it);
        if (!rst && x == 799 && y == 524) model_frame_end();
    endtask

    task automatic probe(string tag);
        drive(mx, my, tag);
        drive(mx + 15, my + 15, tag);
        drive(mx + 16, my, tag);
        drive(mx, my + 16, tag);
        if (mx > 0) drive(mx - 1, my + 5, tag);
        if (my > 0) drive(mx + 5, my - 1, tag);
    endtask

    // Monitor: the output registered at this edge belongs to the last pushed item.
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            vectors++;
            if ({red, grn, blu} !== it.exp) begin
                miscompares++;
                $display("FAIL %s pixel (%0d,%0d): actual %02h expected %02h",
                         it.tag, it.x, it.y, {red, grn, blu}, it.exp);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_home();
        mn = 1;
        // R1: outputs zero while in reset, even on a ball pixel.
        rst = 1'b1;
        drive(100, 100, "R1");
        drive(105, 105, "R1");
        @(negedge clk);
        rst = 1'b0;
        model_home();
        // R1/R3: home corner and square extent.
        probe("R1");
        drive(108, 108, "R3");
        // R4: blanking and black background.
        drive(640, 100, "R4");
        drive(799, 300, "R4");
        drive(100, 480, "R4");
        drive(0, 0, "R4");
        drive(639, 479, "R4");
        // R2: alternating pattern shows one-cycle latency.
        for (int i = 0; i < 6; i++) drive((i % 2) ? 50 : 110, (i % 2) ? 50 : 110, "R2");
        // R6: N = 3, and R5: near-miss coordinates do not count.
        frames_per_move = 8'd3; mn = 3;
        drive(799, 10, "R5");
        drive(799, 523, "R5");
        drive(798, 524, "R5");
        drive(0, 524, "R5");
        probe("R5");
        drive(799, 524, "R6");
        drive(799, 524, "R6");
        probe("R6");
        drive(799, 524, "R6");
        probe("R7");
        drive(101, 101, "R7");
        // R8/R9: every frame, long run through all four bounces.
        frames_per_move = 8'd1; mn = 1;
        for (int i = 0; i < 900; i++) begin
            drive(799, 524, (mdx > 0) ? "R8" : "R9");
            if (mx == 624 || my == 464) probe("R8");
            else if (mx == 0 || my == 0) probe("R9");
            else if (i % 41 == 0) probe("R7");
        end
        // R6: N = 0 moves on every frame end.
        frames_per_move = 8'd0; mn = 0;
        drive(799, 524, "R6");
        probe("R6");
        drive(799, 524, "R6");
        probe("R6");
        // R1: reset mid-run returns home.
        rst = 1'b1;
        drive(mx, my, "R1");
        @(negedge clk);
        rst = 1'b0;
        model_home();
        probe("R1");
        repeat (3) @(posedge clk);
        #6;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule